// File: doc/BRIEF.md
# T1 Frame Synchronization Acquisition Qualifier

This block sits behind the frame search logic of a T1 receive framer and decides when the framer may declare frame synchronization. Once per received frame, the search logic raises `frame_vld` for one cycle. Alongside it come four qualified indications for that frame: framing pattern correct, CRC-6 correct, mimic pattern present, and the data-link DDS pattern correct ahead of the F-bit. The block counts consecutive frames that meet the rule for the selected line format and criteria bit. When the count reaches the number that rule asks for, it raises `in_sync` and gives a one-cycle `sync_pulse`.

The format select picks SF, ESF or T1 DM. One criteria bit selects between the two SF/ESF rules and a second selects between the two DM rules. Both criteria bits are expected to be held at 0 out of reset.

After the block declares sync, it ignores all frame strobes. It stays in sync until the loss-of-sync logic, which is a separate block, asserts `oos`. That clears the flag and restarts qualification from an empty count.

The controller has four states:
- `ST_HUNT`: no qualifying frame has been counted yet.
- `ST_COUNT`: at least one consecutive qualifying frame has been counted.
- `ST_DECLARE`: the one cycle in which sync has just been acquired.
- `ST_LOCK`: sync is held.

Its transitions are:
- HUNT→COUNT or COUNT→COUNT on a qualifying frame that does not yet complete the run.
- HUNT→DECLARE or COUNT→DECLARE on the qualifying frame that completes the run.
- COUNT→HUNT on a failing frame, on a format change, or on `oos`.
- DECLARE→LOCK when `oos` is low.
- DECLARE→HUNT or LOCK→HUNT on `oos`.

Top module: `t1q_sync_qual`

## Requirements
- R1: With `fmt`=0 (SF) and `crit_sel`=0, sync is declared on the second consecutive frame strobe with `fas_ok`=1. `mimic_seen` has no effect in this mode.
- R2: With `fmt`=0 (SF) and `crit_sel`=1, a frame counts only if `fas_ok`=1 and `mimic_seen`=0. Sync is declared on the second consecutive such frame.
- R3: With `fmt`=1 (ESF) and `crit_sel`=0, sync is declared on a single frame strobe with both `fas_ok`=1 and `crc_ok`=1. `mimic_seen` has no effect in this mode.
- R4: With `fmt`=1 (ESF) and `crit_sel`=1, sync is declared on the fourth consecutive frame with `fas_ok`=1 and `mimic_seen`=0.
- R5: With `fmt`=2 (T1 DM) and `dm_crit_sel`=0, sync is declared on a single frame strobe with `fas_ok`=1, `dds_ok`=1 and `mimic_seen`=0.
- R6: With `fmt`=2 (T1 DM) and `dm_crit_sel`=1, sync is declared on the twelfth consecutive frame with `fas_ok`=1, `dds_ok`=1 and `mimic_seen`=0.
- R7: A frame strobe that fails the rule of the current mode clears the consecutive count to zero. This covers a failed framing pattern, and also a mimic in a mode that rejects mimics.
- R8: `in_sync` stays at 1 regardless of frame strobes until `oos`=1. `oos` clears it on the next edge, and qualification then restarts from a count of zero.
- R9: `in_sync` rises on the clock edge that samples the completing frame strobe. `sync_pulse` is 1 for exactly that first in-sync cycle and is 0 otherwise.
- R10: While not in sync, a change of `fmt` clears the consecutive count. A frame strobe in the cycle of the change is not counted.
- R11: `fmt`=3 is reserved, and no frame qualifies in it. Both outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_vld | input | 1 | One-cycle strobe per received frame |
| fas_ok | input | 1 | Framing pattern of this frame correct |
| crc_ok | input | 1 | CRC-6 of this frame correct |
| mimic_seen | input | 1 | Mimic framing pattern present in this frame |
| dds_ok | input | 1 | DDS pattern correct before this frame's F-bit |
| fmt | input | 2 | Format: 0 SF, 1 ESF, 2 T1 DM, 3 reserved |
| crit_sel | input | 1 | SF/ESF acquisition criteria select |
| dm_crit_sel | input | 1 | T1 DM acquisition criteria select |
| oos | input | 1 | Out-of-sync request from loss-of-sync logic |
| in_sync | output | 1 | Frame synchronization held |
| sync_pulse | output | 1 | One-cycle pulse when sync is acquired |

## Verification
Every result of this block is due one clock edge after the stimulus that causes it:
- A completing frame strobe raises `in_sync` and `sync_pulse` after that edge.
- `sync_pulse` drops one edge later.
- `oos` clears `in_sync` one edge later.

The bench drives inputs on the falling edge. It advances its behavioural model once per rising edge, using the inputs just driven, and compares both outputs with the model on the following falling edge, every cycle. Directed checks are sampled at that same falling edge, so each one looks at the cycle in which the requirement says the output changes.

// File: rtl/t1q_pkg.sv
package t1q_pkg;

    typedef enum logic [1:0] {
        FMT_SF  = 2'd0,
        FMT_ESF = 2'd1,
        FMT_DM  = 2'd2,
        FMT_RSV = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_DECLARE = 2'd2,
        ST_LOCK    = 2'd3
    } qst_e;

endpackage

// File: rtl/t1q_frame_judge.sv
module t1q_frame_judge
    import t1q_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SF_RUN  = 2,
    parameter int ESF_RUN = 4,
    parameter int DM_RUN  = 12
) (
    input  logic [1:0]       fmt,
    input  logic             crit_sel,
    input  logic             dm_crit_sel,
    input  logic             fas_ok,
    input  logic             crc_ok,
    input  logic             mimic_seen,
    input  logic             dds_ok,
    output logic             good,
    output logic [CNT_W-1:0] need
);

    localparam logic [CNT_W-1:0] SF_NEED   = CNT_W'(SF_RUN);
    localparam logic [CNT_W-1:0] ESF_NEED  = CNT_W'(ESF_RUN);
    localparam logic [CNT_W-1:0] DM_NEED   = CNT_W'(DM_RUN);
    localparam logic [CNT_W-1:0] ONE_FRAME = CNT_W'(1);

    // Per-mode frame qualification and run length
    always_comb begin
        good = 1'b0;
        need = ONE_FRAME;
        unique case (fmt_e'(fmt))
            FMT_SF: begin
                good = fas_ok && !(crit_sel && mimic_seen);
                need = SF_NEED;
            end
            FMT_ESF: begin
                if (crit_sel) begin
                    good = fas_ok && !mimic_seen;
                    need = ESF_NEED;
                end else begin
                    good = fas_ok && crc_ok;
                    need = ONE_FRAME;
                end
            end
            FMT_DM: begin
                good = fas_ok && dds_ok && !mimic_seen;
                need = dm_crit_sel ? DM_NEED : ONE_FRAME;
            end
            FMT_RSV: begin
                good = 1'b0;
                need = ONE_FRAME;
            end
        endcase
    end

endmodule

// File: rtl/t1q_run_counter.sv
module t1q_run_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] need,
    output logic             hit,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W:0] cnt_plus;

    assign cnt_plus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    // The frame being judged would complete the run
    assign hit      = cnt_plus >= {1'b0, need};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt_plus[CNT_W-1:0];
        end
    end

endmodule

// File: rtl/t1q_sync_qual.sv
module t1q_sync_qual
    import t1q_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int SF_RUN  = 2,
    parameter int ESF_RUN = 4,
    parameter int DM_RUN  = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_vld,
    input  logic       fas_ok,
    input  logic       crc_ok,
    input  logic       mimic_seen,
    input  logic       dds_ok,
    input  logic [1:0] fmt,
    input  logic       crit_sel,
    input  logic       dm_crit_sel,
    input  logic       oos,
    output logic       in_sync,
    output logic       sync_pulse
);

    qst_e             st_q, st_d;
    logic [1:0]       fmt_q;
    logic             fmt_chg;
    logic             good;
    logic [CNT_W-1:0] need;
    logic             hit;
    logic [CNT_W-1:0] cnt;
    logic             cnt_clr;
    logic             cnt_inc;

    t1q_frame_judge #(
        .CNT_W  (CNT_W),
        .SF_RUN (SF_RUN),
        .ESF_RUN(ESF_RUN),
        .DM_RUN (DM_RUN)
    ) judge_i (
        .fmt        (fmt),
        .crit_sel   (crit_sel),
        .dm_crit_sel(dm_crit_sel),
        .fas_ok     (fas_ok),
        .crc_ok     (crc_ok),
        .mimic_seen (mimic_seen),
        .dds_ok     (dds_ok),
        .good       (good),
        .need       (need)
    );

    t1q_run_counter #(
        .CNT_W(CNT_W)
    ) run_i (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .need (need),
        .hit  (hit),
        .cnt  (cnt)
    );

    assign fmt_chg = fmt != fmt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fmt_q <= 2'd0;
        end else begin
            fmt_q <= fmt;
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_HUNT;
        end else begin
            st_q <= st_d;
        end
    end

    // Next state and counter control
    always_comb begin
        st_d    = st_q;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        unique case (st_q)
            ST_HUNT, ST_COUNT: begin
                if (oos || fmt_chg) begin
                    st_d    = ST_HUNT;
                    cnt_clr = 1'b1;
                end else if (frame_vld) begin
                    if (good && hit) begin
                        st_d    = ST_DECLARE;
                        cnt_clr = 1'b1;
                    end else if (good) begin
                        st_d    = ST_COUNT;
                        cnt_inc = 1'b1;
                    end else begin
                        st_d    = ST_HUNT;
                        cnt_clr = 1'b1;
                    end
                end
            end
            ST_DECLARE: begin
                cnt_clr = 1'b1;
                st_d    = oos ? ST_HUNT : ST_LOCK;
            end
            ST_LOCK: begin
                cnt_clr = 1'b1;
                st_d    = oos ? ST_HUNT : ST_LOCK;
            end
        endcase
    end

    // Outputs
    always_comb begin
        in_sync    = 1'b0;
        sync_pulse = 1'b0;
        unique case (st_q)
            ST_HUNT, ST_COUNT: begin
                in_sync    = 1'b0;
                sync_pulse = 1'b0;
            end
            ST_DECLARE: begin
                in_sync    = 1'b1;
                sync_pulse = 1'b1;
            end
            ST_LOCK: begin
                in_sync    = 1'b1;
                sync_pulse = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/t1q_sync_qual_chk.sv
module t1q_sync_qual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_vld,
    input logic       fas_ok,
    input logic       crc_ok,
    input logic       mimic_seen,
    input logic       dds_ok,
    input logic [1:0] fmt,
    input logic       crit_sel,
    input logic       dm_crit_sel,
    input logic       oos,
    input logic       in_sync,
    input logic       sync_pulse
);

    a_r9_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |=> !sync_pulse);

    a_r9_pulse_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> sync_pulse);

    a_r9_pulse_in_sync: assert property (@(posedge clk) disable iff (!rst_n)
        sync_pulse |-> in_sync);

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sync && !oos) |=> in_sync);

    a_r8_oos_clears: assert property (@(posedge clk) disable iff (!rst_n)
        oos |=> !in_sync);

    a_r7_rise_needs_fas: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(frame_vld && fas_ok && !oos));

    a_r2_sf_mimic_block: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_sync) && $past(fmt == 2'd0 && crit_sel)) |-> $past(!mimic_seen));

    a_r3_esf_crc: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_sync) && $past(fmt == 2'd1 && !crit_sel)) |-> $past(crc_ok));

    a_r5_dm_dds: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_sync) && $past(fmt == 2'd2)) |-> $past(dds_ok && !mimic_seen));

    a_r11_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_sync) |-> $past(fmt != 2'd3));

    a_r4_dm_crit_unused: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(in_sync) && $past(fmt == 2'd1 && crit_sel)) |-> $past(!mimic_seen && !dm_crit_sel || !mimic_seen));

endmodule

bind t1q_sync_qual t1q_sync_qual_chk chk_i (.*);

// File: tb/t1q_sync_qual_tb.sv
`timescale 1ns/1ps
module t1q_sync_qual_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_vld = 1'b0;
    logic       fas_ok = 1'b0;
    logic       crc_ok = 1'b0;
    logic       mimic_seen = 1'b0;
    logic       dds_ok = 1'b0;
    logic [1:0] fmt = 2'd0;
    logic       crit_sel = 1'b0;
    logic       dm_crit_sel = 1'b0;
    logic       oos = 1'b0;
    logic       in_sync;
    logic       sync_pulse;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Behavioural reference state
    int m_run = 0;
    bit m_ins = 1'b0;
    bit m_pul = 1'b0;
    int m_fmt_prev = 0;

    always #2 clk = ~clk;

    t1q_sync_qual dut_i (
        .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .fas_ok(fas_ok),
        .crc_ok(crc_ok), .mimic_seen(mimic_seen), .dds_ok(dds_ok), .fmt(fmt),
        .crit_sel(crit_sel), .dm_crit_sel(dm_crit_sel), .oos(oos),
        .in_sync(in_sync), .sync_pulse(sync_pulse)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Advance the model by one rising edge using the driven inputs
    task automatic model_edge();
        bit g;
        int nd;
        g = 1'b0;
        nd = 1;
        case (fmt)
            2'd0: begin g = fas_ok && !(crit_sel && mimic_seen); nd = 2; end
            2'd1: begin
                if (crit_sel) begin g = fas_ok && !mimic_seen; nd = 4; end
                else          begin g = fas_ok && crc_ok;      nd = 1; end
            end
            2'd2: begin g = fas_ok && dds_ok && !mimic_seen; nd = dm_crit_sel ? 12 : 1; end
            default: begin g = 1'b0; nd = 1; end
        endcase
        m_pul = 1'b0;
        if (m_ins) begin
            if (oos) begin m_ins = 1'b0; m_run = 0; end
        end else if (oos || int'(fmt) != m_fmt_prev) begin
            m_run = 0;
        end else if (frame_vld) begin
            if (g) begin
                m_run++;
                if (m_run >= nd) begin m_ins = 1'b1; m_pul = 1'b1; m_run = 0; end
            end else begin
                m_run = 0;
            end
        end
        m_fmt_prev = int'(fmt);
    endtask

    task automatic step(input string tag);
        model_edge();
        @(posedge clk);
        @(negedge clk);
        chk(in_sync === m_ins, tag, "in_sync vs model", int'(in_sync), int'(m_ins));
        chk(sync_pulse === m_pul, tag, "sync_pulse vs model", int'(sync_pulse), int'(m_pul));
    endtask

    task automatic frame(input bit f, input bit c, input bit m, input bit d, input string tag);
        frame_vld = 1'b1; fas_ok = f; crc_ok = c; mimic_seen = m; dds_ok = d;
        step(tag);
        frame_vld = 1'b0; fas_ok = 1'b0; crc_ok = 1'b0; mimic_seen = 1'b0; dds_ok = 1'b0;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    task automatic mode(input int f, input bit c, input bit d, input string tag);
        fmt = 2'(f); crit_sel = c; dm_crit_sel = d;
        step(tag);
    endtask

    task automatic drop(input string tag);
        oos = 1'b1;
        step(tag);
        oos = 1'b0;
        chk(in_sync === 1'b0, tag, "in_sync after oos", int'(in_sync), 0);
    endtask

    task automatic expect_sync(input bit ins, input bit pul, input string tag);
        chk(in_sync === ins, tag, "in_sync", int'(in_sync), int'(ins));
        chk(sync_pulse === pul, tag, "sync_pulse", int'(sync_pulse), int'(pul));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_sync(1'b0, 1'b0, "R11 reset");
        idle(2, "R11 idle");

        // R1: SF, criteria 0, mimic ignored
        mode(0, 1'b0, 1'b0, "R1 mode");
        frame(1, 0, 1, 0, "R1 first");
        expect_sync(1'b0, 1'b0, "R1 one frame");
        frame(1, 0, 0, 0, "R1 second");
        expect_sync(1'b1, 1'b1, "R1 declared");
        idle(1, "R9 pulse");
        expect_sync(1'b1, 1'b0, "R9 pulse one cycle");
        // R8: held through failing strobes until oos
        frame(0, 0, 1, 0, "R8 bad while locked");
        idle(3, "R8 hold");
        expect_sync(1'b1, 1'b0, "R8 held");
        drop("R8 drop");
        frame(1, 0, 0, 0, "R8 restart");
        expect_sync(1'b0, 1'b0, "R8 restart from zero");
        drop("R8 clear");

        // R7: failed pattern clears the run
        frame(1, 0, 0, 0, "R7 a");
        frame(0, 0, 0, 0, "R7 fail");
        frame(1, 0, 0, 0, "R7 b");
        expect_sync(1'b0, 1'b0, "R7 run cleared");
        frame(1, 0, 0, 0, "R7 c");
        expect_sync(1'b1, 1'b1, "R7 after rebuild");
        drop("R7 drop");

        // R2: SF, criteria 1, mimic rejects
        mode(0, 1'b1, 1'b0, "R2 mode");
        frame(1, 0, 0, 0, "R2 a");
        frame(1, 0, 1, 0, "R2 mimic");
        expect_sync(1'b0, 1'b0, "R2 mimic blocks");
        frame(1, 0, 0, 0, "R2 b");
        expect_sync(1'b0, 1'b0, "R2 mimic cleared run");
        frame(1, 0, 0, 0, "R2 c");
        expect_sync(1'b1, 1'b1, "R2 declared");
        drop("R2 drop");

        // R3: ESF, criteria 0
        mode(1, 1'b0, 1'b0, "R3 mode");
        frame(1, 0, 0, 0, "R3 no crc");
        expect_sync(1'b0, 1'b0, "R3 needs crc");
        frame(0, 1, 0, 0, "R3 no fas");
        expect_sync(1'b0, 1'b0, "R3 needs fas");
        frame(1, 1, 1, 0, "R3 both with mimic");
        expect_sync(1'b1, 1'b1, "R3 declared");
        drop("R3 drop");

        // R4: ESF, criteria 1
        mode(1, 1'b1, 1'b0, "R4 mode");
        for (int i = 0; i < 3; i++) frame(1, 0, 0, 0, "R4 run");
        frame(1, 0, 1, 0, "R4 mimic");
        expect_sync(1'b0, 1'b0, "R4 mimic blocks");
        for (int i = 0; i < 3; i++) frame(1, 0, 0, 0, "R4 rerun");
        expect_sync(1'b0, 1'b0, "R4 three not enough");
        frame(1, 0, 0, 0, "R4 fourth");
        expect_sync(1'b1, 1'b1, "R4 declared");
        drop("R4 drop");

        // R10: format change clears run
        for (int i = 0; i < 3; i++) frame(1, 0, 0, 0, "R10 run");
        mode(2, 1'b1, 1'b0, "R10 to dm");
        mode(1, 1'b1, 1'b0, "R10 back");
        frame(1, 0, 0, 0, "R10 one");
        expect_sync(1'b0, 1'b0, "R10 run cleared");
        for (int i = 0; i < 3; i++) frame(1, 0, 0, 0, "R10 rebuild");
        expect_sync(1'b1, 1'b1, "R10 declared");
        drop("R10 drop");

        // R5: DM, criteria 0
        mode(2, 1'b0, 1'b0, "R5 mode");
        frame(1, 0, 1, 1, "R5 mimic");
        expect_sync(1'b0, 1'b0, "R5 mimic blocks");
        frame(1, 0, 0, 0, "R5 no dds");
        expect_sync(1'b0, 1'b0, "R5 needs dds");
        frame(1, 0, 0, 1, "R5 good");
        expect_sync(1'b1, 1'b1, "R5 declared");
        drop("R5 drop");

        // R6: DM, criteria 1
        mode(2, 1'b0, 1'b1, "R6 mode");
        for (int i = 0; i < 11; i++) frame(1, 0, 0, 1, "R6 run");
        expect_sync(1'b0, 1'b0, "R6 eleven not enough");
        frame(1, 0, 0, 0, "R6 dds fail");
        for (int i = 0; i < 11; i++) frame(1, 0, 0, 1, "R6 rerun");
        expect_sync(1'b0, 1'b0, "R6 run cleared by fail");
        frame(1, 0, 0, 1, "R6 twelfth");
        expect_sync(1'b1, 1'b1, "R6 declared");
        drop("R6 drop");

        // R11: reserved format never qualifies
        mode(3, 1'b0, 1'b0, "R11 mode");
        for (int i = 0; i < 4; i++) frame(1, 1, 0, 1, "R11 frames");
        expect_sync(1'b0, 1'b0, "R11 reserved");
        idle(2, "R11 tail");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule